// File: doc/BRIEF.md
# GPIO Pin Configuration Register Bank

This block holds the configuration of thirteen general-purpose pins behind a small synchronous byte-wide register bus. Every pin owns two bytes. The output-control byte selects direction, push-pull or open-drain drive, pull enable, pull strength and polarity, and the level to drive. The input-control byte holds the pin's interrupt edge selection and reports the synchronized pad level. The pins fall into three banks: pins 0 to 6, pins 7 to 10, and pins 11 and 12. All pins share one uniform address layout.

The pad side is modelled as plain per-pin signals: output enable, output data, open-drain select, pull enable, pull select and the raw input. Each pin's 2-bit edge selection goes straight to a separate interrupt block, which does the edge detection.

A host writes a byte by raising the write strobe for one cycle with an address and data. It reads a byte by raising the read strobe. The read data is registered, so it appears one cycle later and holds until the next read.

Top module: `gpio_cfg_bank`

## Requirements
- R1: After a synchronous active-low reset, every output-control byte reads 0x00, all output enables are 0 and every edge selection is 00 (disabled).
- R2: A write to address 0x4E44 + p (p = 0..12) stores the full byte as pin p's output-control byte, and a read of that address returns it. Bit 5 is direction (1 = output), bit 4 is drive (1 = push-pull, 0 = open-drain), bit 3 is pull enable, bits 2:1 are the pull selection and bit 0 is the output level.
- R3: A write to address 0x4E51 + p stores bits 2:1 as pin p's edge selection (00 off, 01 falling, 10 rising, 11 both). The selection appears on irq_edge_mode[2p+1:2p]. A read returns the selection in bits 2:1, with bits 7:3 read as 0. Written bits other than 2:1 have no effect.
- R4: Bit 0 of the input-control byte reads the pad level through a two-flop synchronizer. If the pad changes before rising edge k, a read captured at edge k+1 still returns the old level, and a read captured at edge k+2 returns the new one.
- R5: In push-pull mode (bit 4 = 1), pad_oe equals the direction bit.
- R6: In open-drain mode (bit 4 = 0), pad_od_sel is 1 and pad_oe is 1 only while direction is 1 and the output level is 0. An open-drain pin therefore never drives high.
- R7: pad_out follows output-control bit 0, pad_pull_en follows bit 3, and pad_pull_sel[2p+1:2p] follows bits 2:1 (00 2k down, 01 2k up, 10 50k down, 11 50k up).
- R8: A read of any address outside 0x4E44..0x4E5D returns 0x00, and a write to such an address changes no register.
- R9: bus_rdata updates on the clock edge where bus_rd_en is high and holds its value in every other cycle.
- R10: Writing 0x1A configures a pin as a push-pull input with the 2k pull-up enabled. Writing 0x3A or 0x3B makes it a push-pull output driving 0 or 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr_en | input | 1 | Write strobe, one byte per cycle |
| bus_rd_en | input | 1 | Read strobe |
| bus_addr | input | 16 | Byte address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| pad_in | input | 13 | Raw pad input levels |
| pad_oe | output | 13 | Pad output enables |
| pad_out | output | 13 | Pad output data |
| pad_od_sel | output | 13 | 1 = open-drain drive |
| pad_pull_en | output | 13 | Pull resistor enable |
| pad_pull_sel | output | 26 | Per-pin pull strength and polarity |
| irq_edge_mode | output | 26 | Per-pin edge selection to the interrupt block |

## Verification
The hardest condition to reach is the synchronizer window. The bench must see a read that still returns the stale level after the pad has already changed, then the read that follows it. To get there, it toggles a pad on a falling clock edge and issues back-to-back reads of that pin's input byte starting one cycle later. It then expects the old level from the first read and the new level from the second. Out-of-range accesses just below the first output byte and just above the last input byte are followed by readbacks of the neighbouring registers, which shows those writes were dropped.

// File: rtl/gpio_cfg_pkg.sv
// Package: bit positions and edge-mode encoding shared by the GPIO register bank.
// Assumes byte-wide control registers.
package gpio_cfg_pkg;
    localparam int DIR_BIT     = 5;
    localparam int DRV_BIT     = 4;
    localparam int PULL_EN_BIT = 3;
    localparam int PULL_LO_BIT = 1;
    localparam int LVL_BIT     = 0;
    localparam int EDGE_LO_BIT = 1;

    typedef enum logic [1:0] {
        EDGE_OFF  = 2'b00,
        EDGE_FALL = 2'b01,
        EDGE_RISE = 2'b10,
        EDGE_BOTH = 2'b11
    } edge_mode_e;
endpackage

// File: rtl/gpio_cfg_decode.sv
// Module: address decoder. Maps a byte address to the output-control range,
// the input-control range or neither, plus the pin index inside the range.
// Assumes the input range directly follows the output range.
module gpio_cfg_decode #(
    parameter int NUM_PINS = 13,
    parameter int ADDR_W   = 16,
    parameter int OUT_BASE = 16'h4E44,
    localparam int IDX_W   = $clog2(NUM_PINS)
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit_out,
    output logic              hit_in,
    output logic [IDX_W-1:0]  pin_idx
);
    localparam logic [ADDR_W-1:0] OUT_LO = ADDR_W'(OUT_BASE);
    localparam logic [ADDR_W-1:0] IN_LO  = ADDR_W'(OUT_BASE + NUM_PINS);
    localparam logic [ADDR_W-1:0] IN_END = ADDR_W'(OUT_BASE + 2 * NUM_PINS);

    logic [ADDR_W-1:0] offset;

    // Range compare and offset from the matching base.
    always_comb begin
        hit_out = (addr >= OUT_LO) && (addr < IN_LO);
        hit_in  = (addr >= IN_LO) && (addr < IN_END);
        offset  = addr - (hit_in ? IN_LO : OUT_LO);
        pin_idx = IDX_W'(offset);
    end
endmodule

// File: rtl/gpio_in_sync.sv
// Module: two-flop synchronizer for the pad inputs, one chain per pin.
// Assumes the pad inputs are asynchronous to clk.
module gpio_in_sync #(
    parameter int WIDTH = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] stage1;

    // Two register stages; both clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1   <= '0;
            sync_out <= '0;
        end else begin
            stage1   <= async_in;
            sync_out <= stage1;
        end
    end
endmodule

// File: rtl/gpio_pin_cell.sv
// Module: one pin's configuration storage and pad drive logic.
// Holds the output-control byte and the edge selection; builds both readback bytes.
// Assumes write strobes are already qualified by address.
module gpio_pin_cell
    import gpio_cfg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_out,
    input  logic       wr_in,
    input  logic [7:0] wdata,
    input  logic       pin_lvl,
    output logic [7:0] out_byte,
    output logic [7:0] in_byte,
    output logic       oe,
    output logic       dout,
    output logic       od_sel,
    output logic       pull_en,
    output logic [1:0] pull_sel,
    output logic [1:0] edge_mode
);
    logic [7:0] cfg_q;
    edge_mode_e edge_q;

    // Configuration storage, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q  <= 8'h00;
            edge_q <= EDGE_OFF;
        end else begin
            if (wr_out) cfg_q  <= wdata;
            if (wr_in)  edge_q <= edge_mode_e'(wdata[EDGE_LO_BIT +: 2]);
        end
    end

    // Pad drive: open-drain only pulls low, push-pull follows direction.
    always_comb begin
        dout     = cfg_q[LVL_BIT];
        od_sel   = ~cfg_q[DRV_BIT];
        pull_en  = cfg_q[PULL_EN_BIT];
        pull_sel = cfg_q[PULL_LO_BIT +: 2];
        oe       = cfg_q[DIR_BIT] & (cfg_q[DRV_BIT] | ~cfg_q[LVL_BIT]);
    end

    // Readback bytes.
    always_comb begin
        out_byte  = cfg_q;
        in_byte   = {5'b0, edge_q, pin_lvl};
        edge_mode = edge_q;
    end
endmodule

// File: rtl/gpio_cfg_bank.sv
// Module: top of the GPIO configuration register bank.
// Decodes the byte bus, owns one cell per pin and registers the read data.
// Assumes single-cycle strobes and no simultaneous read and write to one byte matter.
module gpio_cfg_bank #(
    parameter int NUM_PINS = 13,
    parameter int ADDR_W   = 16,
    parameter int OUT_BASE = 16'h4E44
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_wr_en,
    input  logic                  bus_rd_en,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic [7:0]            bus_wdata,
    output logic [7:0]            bus_rdata,
    input  logic [NUM_PINS-1:0]   pad_in,
    output logic [NUM_PINS-1:0]   pad_oe,
    output logic [NUM_PINS-1:0]   pad_out,
    output logic [NUM_PINS-1:0]   pad_od_sel,
    output logic [NUM_PINS-1:0]   pad_pull_en,
    output logic [2*NUM_PINS-1:0] pad_pull_sel,
    output logic [2*NUM_PINS-1:0] irq_edge_mode
);
    localparam int IDX_W = $clog2(NUM_PINS);

    logic             hit_out;
    logic             hit_in;
    logic [IDX_W-1:0] pin_idx;
    logic [NUM_PINS-1:0] pin_lvl;
    logic [7:0]       out_byte [NUM_PINS];
    logic [7:0]       in_byte  [NUM_PINS];
    logic [7:0]       rd_byte;

    gpio_cfg_decode #(
        .NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W), .OUT_BASE(OUT_BASE)
    ) decode_i (
        .addr(bus_addr), .hit_out(hit_out), .hit_in(hit_in), .pin_idx(pin_idx)
    );

    gpio_in_sync #(.WIDTH(NUM_PINS)) sync_i (
        .clk(clk), .rst_n(rst_n), .async_in(pad_in), .sync_out(pin_lvl)
    );

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        logic sel;
        assign sel = (pin_idx == IDX_W'(p));
        gpio_pin_cell cell_i (
            .clk(clk),
            .rst_n(rst_n),
            .wr_out(bus_wr_en & hit_out & sel),
            .wr_in(bus_wr_en & hit_in & sel),
            .wdata(bus_wdata),
            .pin_lvl(pin_lvl[p]),
            .out_byte(out_byte[p]),
            .in_byte(in_byte[p]),
            .oe(pad_oe[p]),
            .dout(pad_out[p]),
            .od_sel(pad_od_sel[p]),
            .pull_en(pad_pull_en[p]),
            .pull_sel(pad_pull_sel[2*p +: 2]),
            .edge_mode(irq_edge_mode[2*p +: 2])
        );
    end

    // Read multiplexer; unmapped addresses give zero.
    always_comb begin
        rd_byte = 8'h00;
        for (int p = 0; p < NUM_PINS; p++) begin
            if (pin_idx == IDX_W'(p)) begin
                if (hit_out) rd_byte = out_byte[p];
                if (hit_in)  rd_byte = in_byte[p];
            end
        end
    end

    // Registered read data, updated only on a read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)         bus_rdata <= 8'h00;
        else if (bus_rd_en) bus_rdata <= rd_byte;
    end
endmodule

// File: rtl/gpio_cfg_bank_chk.sv
// Module: property checker for gpio_cfg_bank, attached by bind.
module gpio_cfg_bank_chk #(
    parameter int NUM_PINS = 13,
    parameter int ADDR_W   = 16,
    parameter int OUT_BASE = 16'h4E44
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  bus_wr_en,
    input logic                  bus_rd_en,
    input logic [ADDR_W-1:0]     bus_addr,
    input logic [7:0]            bus_wdata,
    input logic [7:0]            bus_rdata,
    input logic [NUM_PINS-1:0]   pad_oe,
    input logic [NUM_PINS-1:0]   pad_out,
    input logic [NUM_PINS-1:0]   pad_od_sel,
    input logic [NUM_PINS-1:0]   pad_pull_en,
    input logic [2*NUM_PINS-1:0] irq_edge_mode
);
    localparam logic [ADDR_W-1:0] LO = ADDR_W'(OUT_BASE);
    localparam logic [ADDR_W-1:0] HI = ADDR_W'(OUT_BASE + 2 * NUM_PINS);

    logic oor;
    assign oor = (bus_addr < LO) || (bus_addr >= HI);

    AST_RESET_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (pad_oe == '0 && irq_edge_mode == '0)); // R1

    AST_OOR_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        $past(bus_rd_en && oor) |-> bus_rdata == 8'h00); // R8

    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(bus_rd_en) |-> $stable(bus_rdata)); // R9

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin_chk
        AST_OD_NEVER_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
            (pad_od_sel[i] && pad_oe[i]) |-> !pad_out[i]); // R6

        AST_OUT_WRITE_PAD: assert property (@(posedge clk) disable iff (!rst_n)
            $past(bus_wr_en && bus_addr == ADDR_W'(OUT_BASE + i)) |->
            (pad_out[i] == $past(bus_wdata[0]) && pad_pull_en[i] == $past(bus_wdata[3]))); // R7

        AST_EDGE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
            $past(bus_wr_en && bus_addr == ADDR_W'(OUT_BASE + NUM_PINS + i)) |->
            irq_edge_mode[2*i +: 2] == $past(bus_wdata[2:1])); // R3
    end
endmodule

bind gpio_cfg_bank gpio_cfg_bank_chk #(
    .NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W), .OUT_BASE(OUT_BASE)
) chk_i (
    .clk(clk), .rst_n(rst_n), .bus_wr_en(bus_wr_en), .bus_rd_en(bus_rd_en),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pad_oe(pad_oe), .pad_out(pad_out), .pad_od_sel(pad_od_sel),
    .pad_pull_en(pad_pull_en), .irq_edge_mode(irq_edge_mode)
);

// File: tb/gpio_cfg_bank_tb.sv
`timescale 1ns/1ps
module gpio_cfg_bank_tb_top;
    localparam int N       = 13;
    localparam int OUT_B   = 16'h4E44;
    localparam int IN_B    = OUT_B + N;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr_en = 1'b0;
    logic        bus_rd_en = 1'b0;
    logic [15:0] bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic [N-1:0]   pad_in = '0;
    logic [N-1:0]   pad_oe, pad_out, pad_od_sel, pad_pull_en;
    logic [2*N-1:0] pad_pull_sel, irq_edge_mode;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    gpio_cfg_bank dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr_en(bus_wr_en), .bus_rd_en(bus_rd_en),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pad_in(pad_in), .pad_oe(pad_oe), .pad_out(pad_out),
        .pad_od_sel(pad_od_sel), .pad_pull_en(pad_pull_en),
        .pad_pull_sel(pad_pull_sel), .irq_edge_mode(irq_edge_mode)
    );

    // Vector: {pin[3:0], wdata[7:0], expected oe, expected od_sel}
    localparam logic [13:0] VEC [8] = '{
        {4'd0,  8'h1A, 1'b0, 1'b0},
        {4'd1,  8'h3A, 1'b1, 1'b0},
        {4'd2,  8'h3B, 1'b1, 1'b0},
        {4'd6,  8'h21, 1'b0, 1'b1},
        {4'd7,  8'h20, 1'b1, 1'b1},
        {4'd12, 8'h3F, 1'b1, 1'b0},
        {4'd11, 8'h0E, 1'b0, 1'b1},
        {4'd10, 8'hFB, 1'b1, 1'b0}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [15:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr_en = 1'b1;
        @(posedge clk); @(negedge clk);
        bus_wr_en = 1'b0;
    endtask

    task automatic bus_read(input logic [15:0] a, output logic [7:0] d);
        bus_addr = a; bus_rd_en = 1'b1;
        @(posedge clk); @(negedge clk);
        bus_rd_en = 1'b0;
        d = bus_rdata;
    endtask

    initial begin
        #(200000 * 5);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [7:0] rd;
        logic [7:0] held;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        // R1 reset state
        check("R1 oe", 32'(pad_oe), 0);
        check("R1 edge", 32'(irq_edge_mode), 0);
        bus_read(16'(OUT_B + 5), rd); check("R1 out byte", 32'(rd), 0);
        bus_read(16'(IN_B + 12), rd); check("R1 in byte", 32'(rd), 0);

        // Table walk: R2 R5 R6 R7 R10
        foreach (VEC[k]) begin
            int pin;
            logic [7:0] wd;
            pin = int'(VEC[k][13:10]);
            wd  = VEC[k][9:2];
            bus_write(16'(OUT_B + pin), wd);
            check("R5/R6 oe", 32'(pad_oe[pin]), 32'(VEC[k][1]));
            check("R6 od_sel", 32'(pad_od_sel[pin]), 32'(VEC[k][0]));
            check("R7 out", 32'(pad_out[pin]), 32'(wd[0]));
            check("R7 pull_en", 32'(pad_pull_en[pin]), 32'(wd[3]));
            check("R7 pull_sel", 32'(pad_pull_sel[2*pin +: 2]), 32'(wd[2:1]));
            bus_read(16'(OUT_B + pin), rd);
            check("R2 R10 readback", 32'(rd), 32'(wd));
        end

        // R3 edge selection, bit 0 write ignored
        bus_write(16'(IN_B + 3), 8'h05);
        check("R3 edge pin3", 32'(irq_edge_mode[7:6]), 2);
        bus_read(16'(IN_B + 3), rd); check("R3 in byte pin3", 32'(rd), 8'h04);
        bus_write(16'(IN_B + 8), 8'hFF);
        check("R3 edge pin8", 32'(irq_edge_mode[17:16]), 3);
        bus_read(16'(IN_B + 8), rd); check("R3 in byte pin8", 32'(rd), 8'h06);

        // R4 synchronizer latency
        pad_in[3] = 1'b1;
        @(posedge clk); @(negedge clk);
        bus_read(16'(IN_B + 3), rd); check("R4 stale level", 32'(rd), 8'h04);
        bus_read(16'(IN_B + 3), rd); check("R4 new level", 32'(rd), 8'h05);

        // R8 out-of-range accesses
        bus_write(16'(OUT_B - 1), 8'hFF);
        bus_write(16'(IN_B + N), 8'hFF);
        bus_read(16'(OUT_B - 1), rd); check("R8 low read", 32'(rd), 0);
        bus_read(16'(IN_B + N), rd); check("R8 high read", 32'(rd), 0);
        bus_read(16'(OUT_B), rd); check("R8 pin0 kept", 32'(rd), 8'h1A);
        bus_read(16'(IN_B + 12), rd); check("R8 pin12 in kept", 32'(rd), 0);
        check("R8 edges kept", 32'(irq_edge_mode), (2 << 6) | (3 << 16));

        // R9 read data holds without a read strobe
        bus_read(16'(OUT_B + 12), held);
        bus_write(16'(OUT_B + 4), 8'h3B);
        repeat (2) @(negedge clk);
        check("R9 hold", 32'(bus_rdata), 32'(held));
        check("R9 hold value", 32'(held), 8'h3F);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule